// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Selectable Read-During-Write Policy

This block is a word-addressed memory with one shared address bus for reads and writes. On every rising clock edge the address is captured. The word at that address appears on the read-data output one cycle later. When the write strobe is high in a cycle, the write word is stored at the same address in that cycle. When the strobe is low, the cycle only reads.

A single-port memory always reads the address it writes. The `RDW_MODE` parameter sets what the output shows in a write cycle:

| Value | Policy | Output after a write cycle |
|---|---|---|
| 0 (default) | new word | the word just written |
| 1 | old word | the word stored before the write |
| 2 | hold | the previous output value, unchanged |

Word width, depth and the power-on word are parameters. Every location starts at the power-on word. A synchronous active-high reset returns only the read-data register to that word and leaves the stored words alone.

Top module: `spram_rdw`

## Requirements
- R1: In a cycle with `wr_en` low and `rst` low, `rd_data` after the next rising edge equals the word stored at the address presented before that edge.
- R2: A cycle with `wr_en` low changes no stored word, whatever `wr_word` carries.
- R3: A cycle with `wr_en` high stores `wr_word` at `addr`, and a later read of that address returns it.
- R4: With `RDW_MODE` = 0 (the default), a write cycle puts the written word on `rd_data` one cycle later.
- R5: With `RDW_MODE` = 1, a write cycle puts the word held at that address before the write on `rd_data` one cycle later.
- R6: With `RDW_MODE` = 2, a write cycle leaves `rd_data` at its value from before that edge.
- R7: The `addr` width is clog2(`DEPTH`), with a minimum of 1 bit: 4 bits for a depth of 16, and 1 bit for a depth of 1, whose only word sits at address 0.
- R8: After power-on, every location reads `INIT_WORD`. `INIT_WORD` has type `logic [WIDTH-1:0]`, so it always fits the word width.
- R9: A cycle with `rst` high sets `rd_data` to `INIT_WORD` after that edge and leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the read-data register |
| addr | input | ADDR_W | Shared read/write word address |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_word | input | WIDTH | Word written when `wr_en` is high |
| rd_data | output | WIDTH | Registered read result, one cycle after the address |

## Verification
The assertions check, on every cycle:
- the one-cycle read relation between the stored word and `rd_data`;
- the landing of each write at the captured address;
- the output chosen by the configured policy in every write cycle;
- the value `rd_data` takes after reset.

Some properties can only be shown by the bench's directed scenarios, run against a reference array:
- the power-on contents of every location;
- that pure-read cycles with noisy write data leave memory intact;
- that a reset does not disturb stored words;
- that repeated same-address writes and reads give the same results in all three policy variants side by side;
- the address width of a depth-one memory.

// File: rtl/spram_pkg.sv
package spram_pkg;

    typedef enum int unsigned {
        RDW_NEW  = 0,
        RDW_OLD  = 1,
        RDW_HOLD = 2
    } rdw_mode_e;

    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth <= 1) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/spram_array.sv
module spram_array #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned ADDR_W = spram_pkg::addr_bits(DEPTH),
    parameter logic [WIDTH-1:0] INIT_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_word,
    output logic [WIDTH-1:0]  cur_word
);
    localparam int unsigned SPAN = 1 << ADDR_W;

    logic [WIDTH-1:0] store [DEPTH] = '{default: INIT_WORD};
    logic             in_range;

    generate
        if (SPAN == DEPTH) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_partial
            assign in_range = (32'(addr) < DEPTH);
        end
    endgenerate

    always_comb begin
        cur_word = INIT_WORD;
        if (in_range) cur_word = store[addr];
    end

    always_ff @(posedge clk) begin
        if (wr_en && in_range) store[addr] <= wr_word;
    end

    // R3: a write lands at the captured address
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_range) |=> (store[$past(addr)] == $past(wr_word)));

endmodule

// File: rtl/spram_rdreg.sv
module spram_rdreg #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned RDW_MODE = 0,
    parameter logic [WIDTH-1:0] INIT_WORD = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [WIDTH-1:0] cur_word,
    output logic [WIDTH-1:0] rd_data
);
    import spram_pkg::*;

    logic [WIDTH-1:0] write_view;

    generate
        if (RDW_MODE == RDW_NEW) begin : g_new
            assign write_view = wr_word;
            // R4: new word shown after a write cycle
            assert_new_word_R4: assert property (@(posedge clk) disable iff (rst)
                (!rst && wr_en) |=> (rd_data == $past(wr_word)));
        end else if (RDW_MODE == RDW_OLD) begin : g_old
            assign write_view = cur_word;
            // R5: pre-write word shown after a write cycle
            assert_old_word_R5: assert property (@(posedge clk) disable iff (rst)
                (!rst && wr_en) |=> (rd_data == $past(cur_word)));
        end else if (RDW_MODE == RDW_HOLD) begin : g_hold
            assign write_view = rd_data;
            // R6: output held across a write cycle
            assert_hold_output_R6: assert property (@(posedge clk) disable iff (rst)
                (!rst && wr_en) |=> $stable(rd_data));
        end else begin : g_bad
            $error("spram_rdreg: RDW_MODE must be 0, 1 or 2");
            assign write_view = cur_word;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= INIT_WORD;
        else if (wr_en) rd_data <= write_view;
        else            rd_data <= cur_word;
    end

    // R1: pure read returns the stored word one cycle later
    assert_read_latency_R1: assert property (@(posedge clk) disable iff (rst)
        (!rst && !wr_en) |=> (rd_data == $past(cur_word)));

    // R9: reset loads the power-on word into the output register
    assert_reset_value_R9: assert property (@(posedge clk)
        rst |=> (rd_data == INIT_WORD));

endmodule

// File: rtl/spram_rdw.sv
module spram_rdw #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned RDW_MODE = 0,
    parameter logic [WIDTH-1:0] INIT_WORD = '0,
    localparam int unsigned ADDR_W = spram_pkg::addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_word,
    output logic [WIDTH-1:0]  rd_data
);
    logic [WIDTH-1:0] cur_word;

    spram_array #(
        .WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .INIT_WORD(INIT_WORD)
    ) u_array (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_word(wr_word), .cur_word(cur_word)
    );

    spram_rdreg #(
        .WIDTH(WIDTH), .RDW_MODE(RDW_MODE), .INIT_WORD(INIT_WORD)
    ) u_rdreg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
        .cur_word(cur_word), .rd_data(rd_data)
    );

endmodule

// File: tb/spram_rdw_test.sv
module spram_rdw_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_word = '0;
    logic [7:0] rd_new, rd_old, rd_hold;
    logic [0:0] one_addr = '0;
    logic       one_we = 1'b0;
    logic [7:0] one_word = '0;
    logic [7:0] rd_one;

    int checks = 0;
    int fails = 0;
    logic [7:0] ref_mem [16];
    logic [7:0] hold_exp;

    always #10 clk = ~clk;

    spram_rdw #(.WIDTH(8), .DEPTH(16), .INIT_WORD(8'hA5)) uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_word(wr_word), .rd_data(rd_new));
    spram_rdw #(.WIDTH(8), .DEPTH(16), .RDW_MODE(1), .INIT_WORD(8'hA5)) uut_old (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_word(wr_word), .rd_data(rd_old));
    spram_rdw #(.WIDTH(8), .DEPTH(16), .RDW_MODE(2), .INIT_WORD(8'hA5)) uut_hold (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_word(wr_word), .rd_data(rd_hold));
    spram_rdw #(.WIDTH(8), .DEPTH(1), .INIT_WORD(8'h3C)) uut_one (
        .clk(clk), .rst(rst), .addr(one_addr), .wr_en(one_we),
        .wr_word(one_word), .rd_data(rd_one));

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    // One cycle on the shared bus; checks all three policy variants.
    task automatic step(input logic [3:0] a, input logic w,
                        input logic [7:0] d, input string req);
        logic [7:0] prior;
        prior = ref_mem[a];
        addr = a; wr_en = w; wr_word = d;
        @(negedge clk);
        if (w) begin
            ref_mem[a] = d;
            check("R4", "new-word", rd_new, d);
            check("R5", "old-word", rd_old, prior);
            check("R6", "hold", rd_hold, hold_exp);
        end else begin
            hold_exp = prior;
            check(req, "read new", rd_new, prior);
            check(req, "read old", rd_old, prior);
            check(req, "read hold", rd_hold, prior);
        end
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9", "reset new", rd_new, 8'hA5);
        check("R9", "reset old", rd_old, 8'hA5);
        check("R9", "reset hold", rd_hold, 8'hA5);
        check("R9", "reset one", rd_one, 8'h3C);
        hold_exp = 8'hA5;
        rst = 1'b0;
    endtask

    task automatic t_init_scan;
        for (int i = 0; i < 16; i++) step(4'(i), 1'b0, 8'h00, "R8");
    endtask

    task automatic t_write_then_read;
        for (int i = 0; i < 16; i++) step(4'(i), 1'b1, 8'(8'h10 + i * 7), "R3");
        for (int i = 15; i >= 0; i--) step(4'(i), 1'b0, 8'h00, "R3");
        step(4'd2, 1'b0, 8'h00, "R1");
        step(4'd9, 1'b0, 8'h00, "R1");
    endtask

    task automatic t_pure_read_no_write;
        step(4'd5, 1'b0, 8'hEE, "R2");
        step(4'd5, 1'b0, 8'h01, "R2");
        step(4'd6, 1'b0, 8'h77, "R2");
        step(4'd5, 1'b0, 8'h00, "R2");
        step(4'd6, 1'b0, 8'h00, "R2");
    endtask

    task automatic t_same_addr_back_to_back;
        step(4'd7, 1'b1, 8'h5A, "R4");
        step(4'd7, 1'b1, 8'hC3, "R5");
        step(4'd7, 1'b0, 8'h00, "R1");
        step(4'd7, 1'b1, 8'h99, "R6");
        step(4'd7, 1'b0, 8'h00, "R3");
        step(4'd3, 1'b1, 8'h21, "R6");
        step(4'd4, 1'b1, 8'h42, "R6");
        step(4'd4, 1'b0, 8'h00, "R3");
        step(4'd3, 1'b0, 8'h00, "R3");
    endtask

    task automatic t_reset_keeps_words;
        step(4'd3, 1'b1, 8'h11, "R3");
        addr = 4'd3; wr_en = 1'b0; rst = 1'b1;
        @(negedge clk);
        check("R9", "reset out", rd_new, 8'hA5);
        check("R9", "reset out hold", rd_hold, 8'hA5);
        hold_exp = 8'hA5;
        rst = 1'b0;
        step(4'd3, 1'b0, 8'h00, "R9");
    endtask

    task automatic t_depth_one;
        checks++;
        if ($bits(uut.addr) != 4) begin
            fails++;
            $display("FAIL R7 depth16 width got=%0d exp=4", $bits(uut.addr));
        end
        checks++;
        if ($bits(uut_one.addr) != 1) begin
            fails++;
            $display("FAIL R7 depth1 width got=%0d exp=1", $bits(uut_one.addr));
        end
        one_addr = 1'b0; one_we = 1'b0;
        @(negedge clk);
        check("R7", "depth1 init", rd_one, 8'h3C);
        one_we = 1'b1; one_word = 8'h6B;
        @(negedge clk);
        check("R7", "depth1 write", rd_one, 8'h6B);
        one_we = 1'b0; one_word = 8'h00;
        @(negedge clk);
        check("R7", "depth1 read", rd_one, 8'h6B);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) ref_mem[i] = 8'hA5;
        hold_exp = 8'hA5;
        t_reset();
        t_init_scan();
        t_write_then_read();
        t_pure_read_no_write();
        t_same_addr_back_to_back();
        t_reset_keeps_words();
        t_depth_one();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL R1 watchdog got=timeout exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule